// File: doc/BRIEF.md
# Chained Serial Command Front End

This block is the receive side of a device that sits in a chain of identical devices on one shared serial bus. The clock and data lines are oversampled by the core clock. Data bits are taken on each rising edge of the serial clock, most significant bit first. The bits are grouped into bytes. A byte can carry a link command or start a burst of 32-bit word writes into a bit-addressed register space. During a burst, the serial output returns the previous contents of each word while the new contents arrive.

After reset the device keeps all traffic to itself. A link command can join it to the next device in one of two ways: through a plain wire, or through a flip-flop that delays the stream by one bit. After that the device ignores traffic and only forwards it. To return a device to the isolated state, the host holds the serial clock high and pulses the data line. Each group of pulses resets one device and lets the pulses that follow pass on to the next one.

The storage holds three things. The first is a small array of plain words at the bottom of the address space. The second is a bank of configuration words, each of which drives one enable flag. The third is a pair of speed words whose count of one bits is brought out as a speed setting.

Top module: `chain_spi_slave`

## Requirements
- R1: After `rst_n` is released, `down_mosi_o`, `miso_o`, every bit of `cfg_en_o` and `speed_o` are all 0, and the device is isolated.
- R2: `mosi_i` is sampled on each rising edge of `sck_i`, most significant bit first. The byte 0x04 puts the device in (or keeps it in) the isolated state. While isolated, `down_mosi_o` stays 0 whatever `mosi_i` does.
- R3: After the byte 0x05, `down_mosi_o` follows `mosi_i` within the same cycle. All bytes after it are ignored, including write headers.
- R4: After the byte 0x06, `down_mosi_o` holds the bit sampled at the most recent `sck_i` rising edge, which delays the stream by one bit.
- R5: A write starts with a header byte whose bits 7:5 are 111. Bits 4:0 give the word count minus one. Next comes a 16-bit bit address, high byte first. The first word index is address bits 15:5, so the low five address bits are ignored.
- R6: Each payload byte arrives least significant bit first. The first byte of a word fills word bits 31:24, the next fills 23:16, and so on.
- R7: During the payload, after each sampling edge, `miso_o` shows the previous content of the same word at the bit position just received, in the same serial order. Outside a payload, a sampled bit sets `miso_o` to 0.
- R8: Word index 0x380+n drives `cfg_en_o[n]`. Writing 0xC16A59E3 sets the flag, writing 0 clears it, and any other value leaves it unchanged.
- R9: The two words at word indices 0x300 and 0x301 (bit addresses 0x6000 and 0x6020) form the speed setting. `speed_o` is the number of one bits across both words.
- R10: A byte at a command position that is neither a link command nor a write header is ignored, and the next byte is decoded as a new command.
- R11: If `sck_i` is held high and `mosi_i` completes 3 high pulses, the device returns to the isolated, idle state and drops any partial word. Pulses after that, while `sck_i` stays high, appear on `down_mosi_o`.
- R12: Each word is committed once its 32 payload bits have arrived, at consecutive word indices. A count field of 31 writes 32 words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock, already synchronised |
| mosi_i | input | 1 | Serial data in, already synchronised |
| miso_o | output | 1 | Serial data out (previous word contents) |
| down_sck_o | output | 1 | Serial clock passed to the next device |
| down_mosi_o | output | 1 | Serial data passed to the next device |
| cfg_en_o | output | NUM_CFG | Enable flags from the configuration words |
| speed_o | output | 7 | One-bit count of the speed words |

## Verification
Word patterns with asymmetric bytes are written and then overwritten. The read-back stream therefore exposes any byte-order or bit-order slip, and the enable key only matches if the bit reversal is undone correctly. Bursts of one, two and thirty-two words, with non-zero low address bits, separate a wrong count or a wrong word index from a correct one. Each link mode is tried with alternating data bits, which separates a direct wire from a one-bit delay and from isolation. The bus-level reset is applied in the middle of a burst and in each link mode, which shows both that a partial word is dropped and that later pulses reach the next device.

// File: rtl/chain_spi_pkg.sv
package chain_spi_pkg;
   localparam int WORD_W = 32;
   localparam int ADDR_W = 16;
   localparam int WIDX_W = ADDR_W - 5;

   localparam logic [7:0] OP_BREAK = 8'h04;
   localparam logic [7:0] OP_ASYNC = 8'h05;
   localparam logic [7:0] OP_REG   = 8'h06;
   localparam logic [2:0] HDR_TAG  = 3'b111;

   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR_HI, ST_ADDR_LO, ST_PAYLOAD, ST_FORWARD
   } dec_state_e;

   typedef enum logic [1:0] {
      LINK_ISO, LINK_ASYNC, LINK_REG
   } link_mode_e;
endpackage

// File: rtl/chain_spi_sense.sv
module chain_spi_sense #(
   parameter int RST_PULSES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_i,
   input  logic mosi_i,
   output logic sample_o,
   output logic soft_rst_o,
   output logic rst_pass_o
);
   localparam int CNT_W = $clog2(RST_PULSES + 1);

   logic             sck_q, mosi_q;
   logic [CNT_W-1:0] pcnt_q;
   logic             fall_hi;

   assign sample_o   = sck_i & ~sck_q;
   // a finished data pulse while the clock stays high
   assign fall_hi    = sck_i & sck_q & mosi_q & ~mosi_i;
   assign soft_rst_o = fall_hi && (pcnt_q == CNT_W'(RST_PULSES - 1));
   assign rst_pass_o = sck_i && (pcnt_q == CNT_W'(RST_PULSES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         mosi_q <= 1'b0;
         pcnt_q <= '0;
      end else begin
         sck_q  <= sck_i;
         mosi_q <= mosi_i;
         if (!sck_i)
            pcnt_q <= '0;
         else if (fall_hi && pcnt_q != CNT_W'(RST_PULSES))
            pcnt_q <= pcnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/chain_spi_decode.sv
module chain_spi_decode
   import chain_spi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_i,
   input  logic              soft_rst_i,
   input  logic              mosi_i,
   input  logic [WORD_W-1:0] rd_data_i,
   output logic [WIDX_W-1:0] rd_idx_o,
   output logic              wr_en_o,
   output logic [WIDX_W-1:0] wr_idx_o,
   output logic [WORD_W-1:0] wr_data_o,
   output logic              miso_o,
   output link_mode_e        mode_o,
   output dec_state_e        state_o
);
   dec_state_e        state_q;
   link_mode_e        mode_q;
   logic [2:0]        bcnt_q;
   logic [6:0]        shreg_q;
   logic [4:0]        left_q;
   logic [7:0]        addr_hi_q;
   logic [WIDX_W-1:0] ptr_q;
   logic [4:0]        wbit_q;
   logic [WORD_W-1:0] acc_q, acc_nx;
   logic [7:0]        byte_now;
   logic [4:0]        pos;

   assign byte_now = {shreg_q, mosi_i};
   // bytes fill from the top of the word, each one least significant bit first
   assign pos      = {~wbit_q[4:3], wbit_q[2:0]};
   assign rd_idx_o = ptr_q;
   assign mode_o   = mode_q;
   assign state_o  = state_q;

   always_comb begin
      acc_nx      = acc_q;
      acc_nx[pos] = mosi_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         mode_q    <= LINK_ISO;
         bcnt_q    <= '0;
         shreg_q   <= '0;
         left_q    <= '0;
         addr_hi_q <= '0;
         ptr_q     <= '0;
         wbit_q    <= '0;
         acc_q     <= '0;
         miso_o    <= 1'b0;
         wr_en_o   <= 1'b0;
         wr_idx_o  <= '0;
         wr_data_o <= '0;
      end else begin
         wr_en_o <= 1'b0;
         if (soft_rst_i) begin
            state_q <= ST_IDLE;
            mode_q  <= LINK_ISO;
            bcnt_q  <= '0;
            miso_o  <= 1'b0;
         end else if (sample_i) begin
            unique case (state_q)
               ST_IDLE: begin
                  shreg_q <= byte_now[6:0];
                  bcnt_q  <= bcnt_q + 1'b1;
                  miso_o  <= 1'b0;
                  if (bcnt_q == 3'd7) begin
                     if (byte_now == OP_BREAK)
                        mode_q <= LINK_ISO;
                     else if (byte_now == OP_ASYNC) begin
                        mode_q  <= LINK_ASYNC;
                        state_q <= ST_FORWARD;
                     end else if (byte_now == OP_REG) begin
                        mode_q  <= LINK_REG;
                        state_q <= ST_FORWARD;
                     end else if (byte_now[7:5] == HDR_TAG) begin
                        left_q  <= byte_now[4:0];
                        state_q <= ST_ADDR_HI;
                     end
                  end
               end
               ST_ADDR_HI: begin
                  shreg_q <= byte_now[6:0];
                  bcnt_q  <= bcnt_q + 1'b1;
                  if (bcnt_q == 3'd7) begin
                     addr_hi_q <= byte_now;
                     state_q   <= ST_ADDR_LO;
                  end
               end
               ST_ADDR_LO: begin
                  shreg_q <= byte_now[6:0];
                  bcnt_q  <= bcnt_q + 1'b1;
                  if (bcnt_q == 3'd7) begin
                     ptr_q   <= {addr_hi_q, byte_now[7:5]};
                     wbit_q  <= '0;
                     state_q <= ST_PAYLOAD;
                  end
               end
               ST_PAYLOAD: begin
                  acc_q  <= acc_nx;
                  miso_o <= rd_data_i[pos];
                  wbit_q <= wbit_q + 1'b1;
                  if (wbit_q == 5'd31) begin
                     wr_en_o   <= 1'b1;
                     wr_idx_o  <= ptr_q;
                     wr_data_o <= acc_nx;
                     ptr_q     <= ptr_q + 1'b1;
                     if (left_q == 5'd0) begin
                        state_q <= ST_IDLE;
                        bcnt_q  <= '0;
                     end else
                        left_q <= left_q - 1'b1;
                  end
               end
               ST_FORWARD: ;
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/chain_spi_store.sv
module chain_spi_store
   import chain_spi_pkg::*;
#(
   parameter int          DEPTH      = 8,
   parameter int          NUM_CFG    = 12,
   parameter int          SPEED_BASE = 'h300,
   parameter int          CFG_BASE   = 'h380,
   parameter logic [31:0] CFG_KEY    = 32'hC16A59E3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en_i,
   input  logic [WIDX_W-1:0]  wr_idx_i,
   input  logic [WORD_W-1:0]  wr_data_i,
   input  logic [WIDX_W-1:0]  rd_idx_i,
   output logic [WORD_W-1:0]  rd_data_o,
   output logic [NUM_CFG-1:0] cfg_en_o,
   output logic [6:0]         speed_o
);
   localparam int SPD_WORDS = 2;

   if (DEPTH < 1 || DEPTH > SPEED_BASE) begin : g_bad_depth
      $error("plain word array overlaps the speed words");
   end
   if (SPEED_BASE + SPD_WORDS > CFG_BASE) begin : g_bad_speed
      $error("speed words overlap the configuration words");
   end
   if (NUM_CFG < 1 || CFG_BASE + NUM_CFG > (1 << WIDX_W)) begin : g_bad_cfg
      $error("configuration words exceed the address space");
   end

   logic [DEPTH-1:0][WORD_W-1:0]     mem_flat;
   logic [SPD_WORDS-1:0][WORD_W-1:0] spd_flat;

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(g);
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           word_q <= '0;
         else if (wr_en_i && wr_idx_i == MY_IDX) word_q <= wr_data_i;
      end
      assign mem_flat[g] = word_q;
   end

   for (genvar g = 0; g < SPD_WORDS; g++) begin : g_speed
      localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(SPEED_BASE + g);
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           word_q <= '0;
         else if (wr_en_i && wr_idx_i == MY_IDX) word_q <= wr_data_i;
      end
      assign spd_flat[g] = word_q;
   end

   for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
      localparam logic [WIDX_W-1:0] MY_IDX = WIDX_W'(CFG_BASE + g);
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q <= 1'b0;
         else if (wr_en_i && wr_idx_i == MY_IDX) begin
            if (wr_data_i == CFG_KEY)    flag_q <= 1'b1;
            else if (wr_data_i == '0)    flag_q <= 1'b0;
         end
      end
      assign cfg_en_o[g] = flag_q;
   end

   always_comb begin
      rd_data_o = '0;
      for (int i = 0; i < DEPTH; i++)
         if (rd_idx_i == WIDX_W'(i)) rd_data_o = mem_flat[i];
      for (int i = 0; i < SPD_WORDS; i++)
         if (rd_idx_i == WIDX_W'(SPEED_BASE + i)) rd_data_o = spd_flat[i];
      for (int i = 0; i < NUM_CFG; i++)
         if (rd_idx_i == WIDX_W'(CFG_BASE + i)) rd_data_o = cfg_en_o[i] ? CFG_KEY : '0;
   end

   always_comb begin
      speed_o = '0;
      for (int i = 0; i < SPD_WORDS * WORD_W; i++)
         speed_o = speed_o + 7'(spd_flat[i / WORD_W][i % WORD_W]);
   end
endmodule

// File: rtl/chain_spi_slave.sv
module chain_spi_slave
   import chain_spi_pkg::*;
#(
   parameter int          DEPTH      = 8,
   parameter int          NUM_CFG    = 12,
   parameter int          RST_PULSES = 3,
   parameter int          SPEED_BASE = 'h300,
   parameter int          CFG_BASE   = 'h380,
   parameter logic [31:0] CFG_KEY    = 32'hC16A59E3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_i,
   input  logic               mosi_i,
   output logic               miso_o,
   output logic               down_sck_o,
   output logic               down_mosi_o,
   output logic [NUM_CFG-1:0] cfg_en_o,
   output logic [6:0]         speed_o
);
   if (RST_PULSES < 1) begin : g_bad_pulses
      $error("RST_PULSES must be at least one");
   end

   logic              sample, soft_rst, rst_pass;
   logic              wr_en;
   logic [WIDX_W-1:0] wr_idx, rd_idx;
   logic [WORD_W-1:0] wr_data, rd_data;
   link_mode_e        link_mode;
   dec_state_e        dec_state;
   logic              fwd_q;

   chain_spi_sense #(.RST_PULSES(RST_PULSES)) sense_i (
      .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .mosi_i(mosi_i),
      .sample_o(sample), .soft_rst_o(soft_rst), .rst_pass_o(rst_pass)
   );

   chain_spi_decode decode_i (
      .clk(clk), .rst_n(rst_n), .sample_i(sample), .soft_rst_i(soft_rst),
      .mosi_i(mosi_i), .rd_data_i(rd_data), .rd_idx_o(rd_idx),
      .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
      .miso_o(miso_o), .mode_o(link_mode), .state_o(dec_state)
   );

   chain_spi_store #(
      .DEPTH(DEPTH), .NUM_CFG(NUM_CFG), .SPEED_BASE(SPEED_BASE),
      .CFG_BASE(CFG_BASE), .CFG_KEY(CFG_KEY)
   ) store_i (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
      .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
      .cfg_en_o(cfg_en_o), .speed_o(speed_o)
   );

   // one-bit delay stage for the registered link
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      fwd_q <= 1'b0;
      else if (sample) fwd_q <= mosi_i;
   end

   assign down_sck_o = sck_i;

   always_comb begin
      if (rst_pass) down_mosi_o = mosi_i;
      else begin
         unique case (link_mode)
            LINK_ASYNC: down_mosi_o = mosi_i;
            LINK_REG:   down_mosi_o = fwd_q;
            default:    down_mosi_o = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/chain_spi_slave_chk.sv
module chain_spi_slave_chk
   import chain_spi_pkg::*;
#(
   parameter int NUM_CFG = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mosi_i,
   input logic               miso_o,
   input logic               down_mosi_o,
   input logic [NUM_CFG-1:0] cfg_en_o,
   input link_mode_e         link_mode,
   input dec_state_e         dec_state,
   input logic               wr_en,
   input logic               rst_pass,
   input logic               soft_rst,
   input logic               sample
);
   assert_iso_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (link_mode == LINK_ISO && !rst_pass) |-> !down_mosi_o);

   assert_async_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (link_mode == LINK_ASYNC) |-> (down_mosi_o == mosi_i));

   assert_forward_linked_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_state == ST_FORWARD) |-> (link_mode != LINK_ISO));

   assert_reg_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (link_mode == LINK_REG && !rst_pass && $past(sample)) |-> (down_mosi_o == $past(mosi_i)));

   assert_miso_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_state == ST_IDLE && $past(dec_state) == ST_IDLE && $past(sample)) |-> !miso_o);

   assert_cfg_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(cfg_en_o));

   assert_softrst_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dec_state == ST_IDLE && link_mode == LINK_ISO));

   assert_commit_from_payload_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(dec_state) == ST_PAYLOAD));
endmodule

bind chain_spi_slave chain_spi_slave_chk #(.NUM_CFG(NUM_CFG)) chk_i (
   .clk(clk), .rst_n(rst_n), .mosi_i(mosi_i), .miso_o(miso_o),
   .down_mosi_o(down_mosi_o), .cfg_en_o(cfg_en_o), .link_mode(link_mode),
   .dec_state(dec_state), .wr_en(wr_en), .rst_pass(rst_pass),
   .soft_rst(soft_rst), .sample(sample)
);

// File: tb/chain_spi_slave_tb.sv
module chain_spi_slave_tb_top;
   localparam int NCFG = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            sck = 1'b0;
   logic            mosi = 1'b0;
   logic            miso, dsck, dmosi;
   logic [NCFG-1:0] cfg_en;
   logic [6:0]      speed;

   int n_chk = 0;
   int n_fail = 0;
   logic            down_seen;
   logic [31:0]     wbuf [32];
   logic [31:0]     obuf [32];
   logic [NCFG-1:0] exp_cfg;

   chain_spi_slave dut_i (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .miso_o(miso),
      .down_sck_o(dsck), .down_mosi_o(dmosi), .cfg_en_o(cfg_en), .speed_o(speed)
   );

   always #4 clk = ~clk;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] brev8(input logic [7:0] b);
      logic [7:0] r;
      for (int k = 0; k < 8; k++) r[k] = b[7-k];
      return r;
   endfunction

   // serial order of a word: byte 31:24 first, each byte least significant bit first
   function automatic logic [31:0] to_stream(input logic [31:0] w);
      logic [31:0] s;
      logic [7:0]  rb;
      for (int j = 0; j < 4; j++) begin
         rb = brev8(w[31-8*j -: 8]);
         for (int k = 0; k < 8; k++) s[8*j+k] = rb[7-k];
      end
      return s;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic m);
      mosi = b;
      idle(2);
      sck = 1'b1;
      idle(3);
      m = miso;
      down_seen = dmosi;
      sck = 1'b0;
      idle(2);
   endtask

   task automatic send_byte(input logic [7:0] b);
      logic m;
      for (int i = 7; i >= 0; i--) bit_io(b[i], m);
   endtask

   task automatic burst(input logic [15:0] addr, input int n);
      logic [31:0] s;
      logic m;
      send_byte(8'hE0 | 8'(n - 1));
      send_byte(addr[15:8]);
      send_byte(addr[7:0]);
      for (int w = 0; w < n; w++) begin
         s = to_stream(wbuf[w]);
         for (int t = 0; t < 32; t++) begin
            bit_io(s[t], m);
            obuf[w][t] = m;
         end
      end
      idle(4);
   endtask

   task automatic chain_reset(input int pulses);
      mosi = 1'b0;
      idle(2);
      sck = 1'b1;
      idle(3);
      for (int p = 0; p < pulses; p++) begin
         mosi = 1'b1; idle(3);
         mosi = 1'b0; idle(3);
      end
   endtask

   task automatic t_reset;
      chk("R1 down_mosi", 64'(dmosi), 0);
      chk("R1 miso", 64'(miso), 0);
      chk("R1 cfg_en", 64'(cfg_en), 0);
      chk("R1 speed", 64'(speed), 0);
   endtask

   task automatic t_break;
      send_byte(8'h04);
      mosi = 1'b1;
      idle(2);
      chk("R2 isolated down_mosi", 64'(dmosi), 0);
      mosi = 1'b0;
   endtask

   task automatic t_memory;
      wbuf[0] = 32'h1234_5678; wbuf[1] = 32'hA5C3_0F81;
      burst(16'h0045, 2);
      chk("R7 first read word0", 64'(obuf[0]), 0);
      chk("R7 first read word1", 64'(obuf[1]), 0);
      wbuf[0] = 32'hDEAD_BEEF; wbuf[1] = 32'h0000_FFFF;
      burst(16'h0040, 2);
      chk("R5 R6 R7 old word2", 64'(obuf[0]), 64'(to_stream(32'h1234_5678)));
      chk("R12 R7 old word3", 64'(obuf[1]), 64'(to_stream(32'hA5C3_0F81)));
      wbuf[0] = 32'h0;
      burst(16'h0060, 1);
      chk("R12 word3 kept", 64'(obuf[0]), 64'(to_stream(32'h0000_FFFF)));
   endtask

   task automatic t_cfg;
      wbuf[0] = 32'hC16A59E3;
      burst(16'h7060, 1);
      exp_cfg = 12'h008;
      chk("R8 key enables", 64'(cfg_en), 64'(exp_cfg));
      wbuf[0] = 32'h1234_5678;
      burst(16'h7060, 1);
      chk("R8 other value keeps", 64'(cfg_en), 64'(exp_cfg));
      chk("R7 cfg read back", 64'(obuf[0]), 64'(to_stream(32'hC16A59E3)));
      wbuf[0] = 32'hC16A59E3;
      burst(16'h7160, 1);
      exp_cfg = 12'h808;
      chk("R8 top register", 64'(cfg_en), 64'(exp_cfg));
      wbuf[0] = 32'h0;
      burst(16'h7060, 1);
      exp_cfg = 12'h800;
      chk("R8 zero disables", 64'(cfg_en), 64'(exp_cfg));
   endtask

   task automatic t_speed;
      wbuf[0] = 32'hFFFF_FFFF; wbuf[1] = 32'h7F00_0000;
      burst(16'h6000, 2);
      chk("R9 speed count", 64'(speed), 39);
   endtask

   task automatic t_ignore;
      send_byte(8'h3F);
      send_byte(8'hA0);
      mosi = 1'b1; idle(2);
      chk("R10 no link after junk", 64'(dmosi), 0);
      wbuf[0] = 32'hC16A59E3;
      burst(16'h7000, 1);
      exp_cfg = 12'h801;
      chk("R10 resync to header", 64'(cfg_en), 64'(exp_cfg));
   endtask

   task automatic t_fwd_reg;
      logic [4:0] pat;
      logic m;
      pat = 5'b10110;
      send_byte(8'h06);
      for (int i = 4; i >= 0; i--) begin
         bit_io(pat[i], m);
         chk("R4 delayed bit", 64'(down_seen), 64'(pat[i]));
      end
      mosi = 1'b1; idle(2);
      chk("R4 holds between edges", 64'(dmosi), 0);
      chain_reset(3);
      mosi = 1'b1; idle(3);
      chk("R11 pulse passes on", 64'(dmosi), 1);
      mosi = 1'b0; idle(3);
      chk("R11 pulse low passes", 64'(dmosi), 0);
      sck = 1'b0; idle(3);
      mosi = 1'b1; idle(2);
      chk("R11 isolated after reset", 64'(dmosi), 0);
      wbuf[0] = 32'h0;
      burst(16'h7000, 1);
      exp_cfg = 12'h800;
      chk("R11 decoder idle after reset", 64'(cfg_en), 64'(exp_cfg));
   endtask

   task automatic t_fwd_async;
      send_byte(8'h05);
      mosi = 1'b1; #2;
      chk("R3 wire high", 64'(dmosi), 1);
      mosi = 1'b0; #2;
      chk("R3 wire low", 64'(dmosi), 0);
      wbuf[0] = 32'h0;
      burst(16'h7160, 1);
      chk("R3 header ignored", 64'(cfg_en), 64'(exp_cfg));
      chain_reset(3);
      sck = 1'b0; idle(3);
      mosi = 1'b1; idle(2);
      chk("R11 isolated from forward", 64'(dmosi), 0);
      mosi = 1'b0;
   endtask

   task automatic t_abort;
      logic m;
      send_byte(8'hE0); send_byte(8'h71); send_byte(8'h60);
      for (int t = 0; t < 16; t++) bit_io(1'b0, m);
      chain_reset(3);
      sck = 1'b0; idle(4);
      chk("R11 partial word dropped", 64'(cfg_en), 64'(exp_cfg));
   endtask

   task automatic t_long;
      for (int w = 0; w < 32; w++) wbuf[w] = 32'h0;
      wbuf[30] = 32'hFFFF_FFFF;
      wbuf[31] = 32'h0000_00FF;
      burst(16'h5C40, 32);
      chk("R12 thirty-two words", 64'(speed), 40);
      chk("R7 old speed word0", 64'(obuf[30]), 64'(to_stream(32'hFFFF_FFFF)));
      chk("R7 old speed word1", 64'(obuf[31]), 64'(to_stream(32'h7F00_0000)));
   endtask

   initial begin
      exp_cfg = '0;
      idle(3);
      rst_n = 1'b1;
      idle(3);
      t_reset();
      t_break();
      t_memory();
      t_cfg();
      t_speed();
      t_ignore();
      t_fwd_reg();
      t_fwd_async();
      t_abort();
      t_long();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule